// File: doc/BRIEF.md
# Temperature Alarm Threshold Monitor

This block watches a stream of signed temperature samples. It compares each accepted sample with a high trip level and a low trip level. Each trip level has its own hysteresis level. From these comparisons the block keeps two status flags: one for over-temperature (OT) and one for under-temperature (UT). It also drives a single alarm line. The alarm line is modelled as an open-drain pin with an external pull-up, so the block only ever produces a pull-down enable.

The block has two reporting styles:

- **Comparator style.** Each flag follows the temperature, and hysteresis keeps it from chattering.
- **Interrupt style.** A flag records one event and holds it until a status read clears it. The next event on that flag then fires at the opposite crossing (back through the hysteresis level), and the two crossings keep alternating.

A fault-queue selector sets how many consecutive out-of-range samples are needed before a trip event counts. Samples are two's complement with 1/16 °C per LSB. The package holds power-on values for the thresholds, which integration logic can use: +100 °C high, +90 °C high hysteresis, −40 °C low and −30 °C low hysteresis.

Top module: `temp_alarm_monitor`

## Requirements
- R1: In comparator style, OT becomes 1 on the clock edge that accepts a qualified sample strictly greater than `th_i`. A sample equal to `th_i` is not a fault.
- R2: In comparator style, a set OT clears on the clock edge that accepts a sample strictly below `th_hyst_i`. For samples from `th_hyst_i` up to `th_i`, OT holds its value.
- R3: UT mirrors OT. In comparator style, UT sets on a qualified sample strictly below `tl_i` and clears on a sample strictly above `tl_hyst_i`. In interrupt style, the alternate UT event is a sample strictly above `tl_hyst_i`.
- R4: `fq_sel_i` values 0, 1, 2 and 3 require 1, 2, 4 and 8 consecutive accepted out-of-range samples. Any accepted sample that is not beyond the trip level restarts the count.
- R5: The high side and the low side keep separate consecutive-fault counts. A low-side fault never advances the high-side count.
- R6: In interrupt style (`int_mode_i`=1), a qualified trip sets the flag, and the flag then holds until a `status_rd_i` pulse clears it. In comparator style, `status_rd_i` has no effect.
- R7: In interrupt style, after an event has been cleared, the next event on that flag fires only on the opposite crossing: below `th_hyst_i` for OT, above `tl_hyst_i` for UT. The direction alternates with each event. No new event is recorded while the flag is still set.
- R8: While `shutdown_i` is 1, both flags are 0 from the next edge on, samples are ignored and counts are cleared. Both sides re-arm for a trip-level event.
- R9: `alarm_oe_o` (1 = pull the pin low) depends on `pol_high_i`. With `pol_high_i`=0, it is 1 exactly when OT or UT is set. With `pol_high_i`=1, it is 1 exactly when neither flag is set.
- R10: Only cycles with `sample_valid_i`=1 are accepted samples. With no sample, no read and no shutdown, both flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe |
| temp_i | input | TEMP_W | Signed sample, 1/16 °C per LSB |
| th_i | input | TEMP_W | High trip level |
| th_hyst_i | input | TEMP_W | High hysteresis level |
| tl_i | input | TEMP_W | Low trip level |
| tl_hyst_i | input | TEMP_W | Low hysteresis level |
| int_mode_i | input | 1 | 0 = comparator style, 1 = interrupt style |
| pol_high_i | input | 1 | 0 = alarm active low, 1 = alarm active high |
| fq_sel_i | input | QSEL_W | Fault-queue depth select (depth 2^value) |
| status_rd_i | input | 1 | Status read pulse (clears flags in interrupt style) |
| shutdown_i | input | 1 | Shutdown: clears flags and ignores samples |
| ot_o | output | 1 | Over-temperature flag |
| ut_o | output | 1 | Under-temperature flag |
| alarm_oe_o | output | 1 | Open-drain pull-down enable |

## Verification
The bench targets the following corner cases, and each one exposes a specific wrong design:

- **Samples exactly on each boundary.** A design that compares with ≥ or ≤ trips at `th_i` or releases at `th_hyst_i`.
- **Fault runs broken by an in-range sample.** A design that does not restart its count raises the flag too early.
- **A low fault placed before a high fault at depth 2.** This catches a design with a single shared counter.
- **Interrupt sequences.** These prove the alternating re-arm, the hold until a read, and that a read does nothing in comparator style. A design that re-arms on the same crossing fires again at the trip level instead of at the hysteresis level.
- **Shutdown.** The bench shows that shutdown clears the flags, discards samples and re-arms the trip direction.
- **Both alarm polarities.** These show the pull-down enable inverting correctly.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;
  localparam int LSB_PER_DEG = 16;
  localparam int TH_DEF      = 100 * LSB_PER_DEG;
  localparam int TH_HYST_DEF = 90 * LSB_PER_DEG;
  localparam int TL_DEF      = -40 * LSB_PER_DEG;
  localparam int TL_HYST_DEF = -30 * LSB_PER_DEG;

  typedef enum logic {
    MODE_CMP = 1'b0,
    MODE_INT = 1'b1
  } alarm_mode_e;

  localparam int DIR_HI = 0;
  localparam int DIR_LO = 1;
  localparam int N_DIR  = 2;
endpackage

// File: rtl/threshold_cmp.sv
module threshold_cmp #(
  parameter int TEMP_W = 16
) (
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic signed [TEMP_W-1:0] th_i,
  input  logic signed [TEMP_W-1:0] th_hyst_i,
  input  logic signed [TEMP_W-1:0] tl_i,
  input  logic signed [TEMP_W-1:0] tl_hyst_i,
  output logic [temp_alarm_pkg::N_DIR-1:0] beyond_o,
  output logic [temp_alarm_pkg::N_DIR-1:0] back_o
);
  import temp_alarm_pkg::*;

  always_comb begin
    beyond_o[DIR_HI] = temp_i > th_i;
    back_o[DIR_HI]   = temp_i < th_hyst_i;
    beyond_o[DIR_LO] = temp_i < tl_i;
    back_o[DIR_LO]   = temp_i > tl_hyst_i;
  end
endmodule

// File: rtl/fault_qual.sv
module fault_qual #(
  parameter int QSEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              fault_i,
  input  logic [QSEL_W-1:0] sel_i,
  output logic              qual_o
);
  localparam int MAX_DEPTH = 1 << ((1 << QSEL_W) - 1);
  localparam int CNT_W     = $clog2(MAX_DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_inc, depth;

  always_comb begin
    depth   = CNT_W'(1) << sel_i;
    cnt_inc = (cnt_q == CNT_W'(MAX_DEPTH)) ? cnt_q : cnt_q + CNT_W'(1);
    qual_o  = step_i && fault_i && (cnt_inc >= depth);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= fault_i ? cnt_inc : '0;
  end
endmodule

// File: rtl/status_track.sv
module status_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic int_mode_i,
  input  logic rd_clr_i,
  input  logic qual_beyond_i,
  input  logic back_i,
  output logic stat_o
);
  import temp_alarm_pkg::*;

  logic stat_q, arm_trip_q, int_ev;
  alarm_mode_e mode;

  assign mode   = alarm_mode_e'(int_mode_i);
  // interrupt event: only while flag clear, direction picked by arm state
  assign int_ev = step_i && !stat_q && (arm_trip_q ? qual_beyond_i : back_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q     <= 1'b0;
      arm_trip_q <= 1'b1;
    end else if (clr_i) begin
      stat_q     <= 1'b0;
      arm_trip_q <= 1'b1;
    end else if (mode == MODE_CMP) begin
      arm_trip_q <= 1'b1;
      if (step_i && qual_beyond_i) stat_q <= 1'b1;
      else if (step_i && back_i)   stat_q <= 1'b0;
    end else begin
      if (int_ev) begin
        stat_q     <= 1'b1;
        arm_trip_q <= ~arm_trip_q;
      end else if (rd_clr_i) begin
        stat_q <= 1'b0;
      end
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/temp_alarm_monitor.sv
module temp_alarm_monitor #(
  parameter int TEMP_W = 16,
  parameter int QSEL_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_valid_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic signed [TEMP_W-1:0] th_i,
  input  logic signed [TEMP_W-1:0] th_hyst_i,
  input  logic signed [TEMP_W-1:0] tl_i,
  input  logic signed [TEMP_W-1:0] tl_hyst_i,
  input  logic                     int_mode_i,
  input  logic                     pol_high_i,
  input  logic [QSEL_W-1:0]        fq_sel_i,
  input  logic                     status_rd_i,
  input  logic                     shutdown_i,
  output logic                     ot_o,
  output logic                     ut_o,
  output logic                     alarm_oe_o
);
  import temp_alarm_pkg::*;

  logic [N_DIR-1:0] beyond, back, qual, stat;
  logic step, alarm_act;

  assign step = sample_valid_i && !shutdown_i;

  threshold_cmp #(.TEMP_W(TEMP_W)) u_cmp (
    .temp_i   (temp_i),
    .th_i     (th_i),
    .th_hyst_i(th_hyst_i),
    .tl_i     (tl_i),
    .tl_hyst_i(tl_hyst_i),
    .beyond_o (beyond),
    .back_o   (back)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    fault_qual #(.QSEL_W(QSEL_W)) u_fq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (shutdown_i),
      .step_i (step),
      .fault_i(beyond[d]),
      .sel_i  (fq_sel_i),
      .qual_o (qual[d])
    );

    status_track u_st (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (shutdown_i),
      .step_i       (step),
      .int_mode_i   (int_mode_i),
      .rd_clr_i     (status_rd_i),
      .qual_beyond_i(qual[d]),
      .back_i       (back[d]),
      .stat_o       (stat[d])
    );
  end

  assign ot_o      = stat[DIR_HI];
  assign ut_o      = stat[DIR_LO];
  assign alarm_act = |stat;
  // pin must sit low when the active level is low and alarm is on, or high level and idle
  assign alarm_oe_o = pol_high_i ? ~alarm_act : alarm_act;
endmodule

// File: rtl/temp_alarm_chk.sv
module temp_alarm_chk #(
  parameter int TEMP_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sample_valid_i,
  input logic signed [TEMP_W-1:0] temp_i,
  input logic signed [TEMP_W-1:0] th_i,
  input logic signed [TEMP_W-1:0] th_hyst_i,
  input logic                     int_mode_i,
  input logic                     pol_high_i,
  input logic                     status_rd_i,
  input logic                     shutdown_i,
  input logic                     ot_o,
  input logic                     ut_o,
  input logic                     alarm_oe_o
);
  // R8
  shutdown_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_i |=> (!ot_o && !ut_o));

  // R2
  ot_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_mode_i && !shutdown_i && sample_valid_i && temp_i < th_hyst_i && temp_i <= th_i)
    |=> !ot_o);

  // R6
  int_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mode_i && ot_o && !status_rd_i && !shutdown_i) |=> ot_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_valid_i && !status_rd_i && !shutdown_i) |=> ($stable(ot_o) && $stable(ut_o)));

  // R1
  ot_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ot_o) && !$past(int_mode_i)) |-> ($past(sample_valid_i) && ($past(temp_i) > $past(th_i))));

  // R9
  pol_high_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_high_i && (ot_o || ut_o)) |-> !alarm_oe_o);
endmodule

bind temp_alarm_monitor temp_alarm_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_valid_i(sample_valid_i),
  .temp_i        (temp_i),
  .th_i          (th_i),
  .th_hyst_i     (th_hyst_i),
  .int_mode_i    (int_mode_i),
  .pol_high_i    (pol_high_i),
  .status_rd_i   (status_rd_i),
  .shutdown_i    (shutdown_i),
  .ot_o          (ot_o),
  .ut_o          (ut_o),
  .alarm_oe_o    (alarm_oe_o)
);

// File: tb/sim_temp_alarm_monitor.sv
`timescale 1ns/1ps
module sim_temp_alarm_monitor;
  import temp_alarm_pkg::*;
  localparam int TEMP_W = 16;
  localparam int QSEL_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sv = 1'b0, imode = 1'b0, polh = 1'b0, rd = 1'b0, sd = 1'b0;
  logic [QSEL_W-1:0] fq = '0;
  logic signed [TEMP_W-1:0] temp = '0;
  logic signed [TEMP_W-1:0] th = TEMP_W'(TH_DEF), thh = TEMP_W'(TH_HYST_DEF);
  logic signed [TEMP_W-1:0] tl = TEMP_W'(TL_DEF), tlh = TEMP_W'(TL_HYST_DEF);
  logic ot, ut, oe;

  int n_chk = 0, n_fail = 0;
  bit [2:0] q_exp[$];
  string    q_tag[$];
  bit       done = 1'b0;

  always #4 clk = ~clk;

  temp_alarm_monitor #(.TEMP_W(TEMP_W), .QSEL_W(QSEL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sv), .temp_i(temp),
    .th_i(th), .th_hyst_i(thh), .tl_i(tl), .tl_hyst_i(tlh),
    .int_mode_i(imode), .pol_high_i(polh), .fq_sel_i(fq),
    .status_rd_i(rd), .shutdown_i(sd), .ot_o(ot), .ut_o(ut), .alarm_oe_o(oe)
  );

  task automatic check(input bit [2:0] act, input bit [2:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {ot,ut,oe} actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver: one cycle per call, expectation queued for the monitor
  task automatic drv(input int t, input bit v, input bit r, input bit s,
                     input bit eo, input bit eu, input string tag);
    bit eoe;
    @(negedge clk);
    temp = TEMP_W'(t); sv = v; rd = r; sd = s;
    eoe = polh ? !(eo || eu) : (eo || eu);  // R9
    q_exp.push_back({eo, eu, eoe});
    q_tag.push_back(tag);
  endtask

  task automatic smp(input int t, input bit eo, input bit eu, input string tag);
    drv(t, 1'b1, 1'b0, 1'b0, eo, eu, tag);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) check({ot, ut, oe}, q_exp.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({ot, ut, oe}, 3'b000, "reset state");
    rst_n = 1'b1;
    // comparator style, depth 1
    smp(0,     0, 0, "R10 in range");
    smp(1600,  0, 0, "R1 equal to trip");
    smp(1601,  1, 0, "R1 above trip / R9 low pol");
    smp(1500,  1, 0, "R2 between");
    smp(1440,  1, 0, "R2 equal hyst");
    smp(1439,  0, 0, "R2 below hyst");
    drv(2000, 1'b0, 1'b0, 1'b0, 0, 0, "R10 no valid ignored");
    smp(-640,  0, 0, "R3 equal low trip");
    smp(-641,  0, 1, "R3 below low trip");
    smp(-500,  0, 1, "R3 between");
    smp(-480,  0, 1, "R3 equal low hyst");
    smp(-479,  0, 0, "R3 above low hyst");
    smp(1700,  1, 0, "R1 set");
    drv(1700, 1'b1, 1'b1, 1'b0, 1, 0, "R6 read ignored in comparator");
    drv(0,    1'b0, 1'b1, 1'b0, 1, 0, "R6 read ignored in comparator idle");
    smp(1000,  0, 0, "R2 clear");
    // fault queue depth 4
    @(negedge clk); fq = 2'd2;
    smp(2000, 0, 0, "R4 run 1");
    smp(2000, 0, 0, "R4 run 2");
    smp(2000, 0, 0, "R4 run 3");
    smp(2000, 1, 0, "R4 run 4 trips");
    smp(1000, 0, 0, "R4 clear");
    smp(2000, 0, 0, "R4 restart 1");
    smp(2000, 0, 0, "R4 restart 2");
    smp(2000, 0, 0, "R4 restart 3");
    smp(1500, 0, 0, "R4 break run");
    smp(2000, 0, 0, "R4 after break 1");
    smp(2000, 0, 0, "R4 after break 2");
    smp(2000, 0, 0, "R4 after break 3");
    smp(2000, 1, 0, "R4 after break 4");
    smp(1000, 0, 0, "R4 clear again");
    // separate counters, depth 2
    @(negedge clk); fq = 2'd1;
    smp(-700, 0, 0, "R5 low fault first");
    smp(2000, 0, 0, "R5 high count not shared");
    smp(2000, 1, 0, "R5 high second");
    smp(1000, 0, 0, "R5 clear");
    @(negedge clk); fq = 2'd0;
    // active-high polarity
    @(negedge clk); polh = 1'b1;
    smp(0,    0, 0, "R9 high pol idle pulls low");
    smp(1700, 1, 0, "R9 high pol alarm released");
    smp(1000, 0, 0, "R9 high pol clear");
    @(negedge clk); polh = 1'b0;
    // interrupt style
    @(negedge clk); imode = 1'b1;
    smp(1700, 1, 0, "R6 trip event");
    smp(1000, 1, 0, "R6 held in range");
    drv(1000, 1'b1, 1'b1, 1'b0, 0, 0, "R6 read clears");
    smp(1700, 0, 0, "R7 trip not rearmed");
    smp(1500, 0, 0, "R7 between");
    smp(1400, 1, 0, "R7 hyst crossing event");
    drv(1400, 1'b1, 1'b1, 1'b0, 0, 0, "R7 read clears");
    smp(1400, 0, 0, "R7 rearmed for trip");
    smp(1700, 1, 0, "R7 trip again");
    drv(1700, 1'b0, 1'b1, 1'b0, 0, 0, "R6 read clears idle");
    smp(1400, 1, 0, "R7 hyst event again");
    drv(1400, 1'b0, 1'b1, 1'b0, 0, 0, "R7 read rearm trip");
    smp(-700, 0, 1, "R3 low interrupt event");
    drv(-700, 1'b1, 1'b1, 1'b0, 0, 0, "R3 low read clears");
    smp(-500, 0, 0, "R3 not above low hyst");
    smp(-470, 0, 1, "R3 alternate low event");
    drv(-470, 1'b0, 1'b1, 1'b0, 0, 0, "R3 low read clears");
    // shutdown
    smp(1700, 1, 0, "R8 set before shutdown");
    drv(1700, 1'b1, 1'b0, 1'b1, 0, 0, "R8 shutdown clears");
    drv(2000, 1'b1, 1'b0, 1'b1, 0, 0, "R8 samples ignored");
    smp(1400, 0, 0, "R8 rearmed for trip");
    smp(1700, 1, 0, "R8 trip after shutdown");
    @(negedge clk); imode = 1'b0;
    smp(1000, 0, 0, "R2 back to comparator");
    smp(-700, 0, 1, "R8 low set");
    drv(-700, 1'b1, 1'b0, 1'b1, 0, 0, "R8 shutdown clears low");
    drv(0, 1'b0, 1'b0, 1'b0, 0, 0, "R10 idle after shutdown");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule